// File: doc/BRIEF.md
# Timer Channel Tick Gate and Prescaler

This block sits between a set of free-running tick sources and the counters of a timer bank. It holds one stop bit and one 16-bit control word for each channel. The bank has up to eight general timers, an optional OS-timer channel and a watchdog channel. Each control word picks one of three tick sources and a power-of-four division ratio. Each running channel turns its selected source pulses into a divided, single-cycle tick-enable pulse in the system clock domain. A stopped channel is silent.

Software reaches the block over a small synchronous register bus. The bus has a word address, 32-bit write data, a write strobe and combinational read data. Stop bits are never written directly. One write-only register sets them and another clears them, both by writing ones. A status register reads them all back. Word addresses: 0 status (read-only), 1 stop-set (write-only), 2 stop-clear (write-only), 8+i control of timer i, 16 OS-timer control, 17 watchdog control. Every other address reads 0 and ignores writes.

Top module: `timer_clk_ctrl`

## Requirements
- R1: After reset every implemented stop bit is 1, every control word reads 0 and every tick output is low.
- R2: A write to the stop-set register (address 1) sets each implemented stop bit whose data bit is 1. Bits written as 0 keep their value.
- R3: A write to the stop-clear register (address 2) clears each implemented stop bit whose data bit is 1. Bits written as 0 keep their value.
- R4: The status register (address 0) returns the stop bits, with 1 meaning stopped. Timer i uses bit i, the OS timer uses bit 15 and the watchdog uses bit 16. All other bits read 0.
- R5: A control write (addresses 8+i, 16, 17) takes effect only while that channel's stop bit is 0. A write while the channel is stopped leaves the word unchanged. The word is 16 bits wide, and data bits above 15 are dropped; it reads back in bits [15:0] of the read data.
- R6: Control bits [2:0] select the source. Bit 0 selects the peripheral tick, bit 1 the RTC tick and bit 2 the external tick. The lowest set bit wins, and with none set the channel emits nothing.
- R7: Control bits [5:3] hold a prescale code n. The channel emits one pulse per 4^n selected source ticks. Codes 6 and 7 act as 5, which gives division by 1024.
- R8: An output pulse is one cycle wide. It appears in the cycle after the clock edge that samples the source tick completing the division.
- R9: A stopped channel emits no pulses and its prescale count returns to zero. After release, division restarts from a fresh count.
- R10: A control write that changes bits [5:0] restarts the prescale count from zero.
- R11: Stop bits, status bits and control registers of channels that are not built, together with the write-only registers, read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pclk_tick_i | input | 1 | Peripheral-clock tick enable |
| rtc_tick_i | input | 1 | RTC tick enable |
| ext_tick_i | input | 1 | External tick enable |
| tmr_tick_o | output | NUM_TIMERS | Divided tick pulse per timer channel |
| ost_tick_o | output | 1 | Divided tick pulse of the OS-timer channel (0 if not built) |
| wdt_tick_o | output | 1 | Divided tick pulse of the watchdog channel |

## Verification
The assertions assume that a single bus write targets a single address, so stop-set and stop-clear never land in the same cycle. They also assume that the source tick inputs are known values once reset is released. The bench follows both rules. It drives bus writes and source pulses only at falling edges, one source pulse per two cycles, and keeps all source inputs low during register writes. As a result, no division restart coincides with a completing tick.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int CTRL_W   = 16;
  localparam int SRC_W    = 3;
  localparam int PSC_LSB  = 3;
  localparam int PSC_W    = 3;
  localparam int PSC_MAX  = 5;
  localparam int CNT_W    = 2 * PSC_MAX;
  localparam int CFG_W    = PSC_LSB + PSC_W;
  localparam int TMR_MAX  = 8;
  localparam int OST_BIT  = 15;
  localparam int WDT_BIT  = 16;

  localparam int A_STATUS = 0;
  localparam int A_SET    = 1;
  localparam int A_CLR    = 2;
  localparam int A_TMR    = 8;
  localparam int A_OST    = 16;
  localparam int A_WDT    = 17;

  typedef enum logic [1:0] {SRC_NONE, SRC_PCLK, SRC_RTC, SRC_EXT} src_e;

  // lowest set select bit wins
  function automatic src_e pick_src(input logic [SRC_W-1:0] sel);
    if (sel[0])      return SRC_PCLK;
    else if (sel[1]) return SRC_RTC;
    else if (sel[2]) return SRC_EXT;
    else             return SRC_NONE;
  endfunction

  // terminal count for a 4^n divider; codes above PSC_MAX saturate
  function automatic logic [CNT_W-1:0] div_limit(input logic [PSC_W-1:0] code);
    int unsigned n;
    n = (code > PSC_W'(PSC_MAX)) ? PSC_MAX : int'(code);
    return CNT_W'((1 << (2 * n)) - 1);
  endfunction

  function automatic logic [31:0] impl_mask(input int ntmr, input bit has_ost);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < ntmr; i++) m[i] = 1'b1;
    m[OST_BIT] = has_ost;
    m[WDT_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tcc_stop_bank.sv
module tcc_stop_bank #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] IMPL_MASK = 32'h0001_00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stop_o
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(IMPL_MASK);

  logic [DATA_W-1:0] stop_q;
  logic [DATA_W-1:0] hit;

  assign hit = wdata & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n)      stop_q <= MASK;
    else if (set_we) stop_q <= stop_q | hit;
    else if (clr_we) stop_q <= stop_q & ~hit;
  end

  assign stop_o = stop_q;

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((stop_q & $past(hit)) == $past(hit)));
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((stop_q & $past(hit)) == '0));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(stop_q));
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stopped,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [SRC_W-1:0]  src_ticks,   // {ext, rtc, pclk}
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              tick_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              tick_q;

  // named internal events
  logic              wr_ok;
  logic              cfg_change;
  src_e              src;
  logic              sel_tick;
  logic [CNT_W-1:0]  limit;
  logic              wrap;

  assign wr_ok      = wr_en && !stopped;
  assign cfg_change = wr_ok && (wr_data[CFG_W-1:0] != ctrl_q[CFG_W-1:0]);
  assign src        = pick_src(ctrl_q[SRC_W-1:0]);
  assign limit      = div_limit(ctrl_q[PSC_LSB +: PSC_W]);

  always_comb begin
    unique case (src)
      SRC_PCLK: sel_tick = src_ticks[0];
      SRC_RTC:  sel_tick = src_ticks[1];
      SRC_EXT:  sel_tick = src_ticks[2];
      default:  sel_tick = 1'b0;
    endcase
  end

  assign wrap = sel_tick && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (wr_ok) ctrl_q <= wr_data;
      if (stopped || cfg_change) cnt_q <= '0;
      else if (wrap)             cnt_q <= '0;
      else if (sel_tick)         cnt_q <= cnt_q + 1'b1;
      tick_q <= wrap && !stopped && !cfg_change;
    end
  end

  assign ctrl_o = ctrl_q;
  assign tick_o = tick_q;

  p_ctrl_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> $stable(ctrl_q));
  p_gated_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> (!tick_o && cnt_q == '0));
  p_cfg_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (cnt_q == '0 && !tick_o));
  p_no_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_NONE) |=> !tick_o);
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
  p_tick_needs_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_tick |=> !tick_o);
endmodule

// File: rtl/timer_clk_ctrl.sv
module timer_clk_ctrl
  import tcc_pkg::*;
#(
  parameter int NUM_TIMERS = 8,
  parameter bit HAS_OST    = 1'b1,
  parameter int ADDR_W     = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_we,
  output logic [31:0]           bus_rdata,
  input  logic                  pclk_tick_i,
  input  logic                  rtc_tick_i,
  input  logic                  ext_tick_i,
  output logic [NUM_TIMERS-1:0] tmr_tick_o,
  output logic                  ost_tick_o,
  output logic                  wdt_tick_o
);
  localparam logic [31:0] IMPL_MASK = impl_mask(NUM_TIMERS, HAS_OST);

  logic [31:0]       stop_q;
  logic [SRC_W-1:0]  src_ticks;
  logic [CTRL_W-1:0] tmr_ctrl [TMR_MAX];
  logic [TMR_MAX-1:0] tmr_tick_all;
  logic [CTRL_W-1:0] ost_ctrl, wdt_ctrl;
  logic              set_we, clr_we;

  assign src_ticks = {ext_tick_i, rtc_tick_i, pclk_tick_i};
  assign set_we    = bus_we && (bus_addr == ADDR_W'(A_SET));
  assign clr_we    = bus_we && (bus_addr == ADDR_W'(A_CLR));

  tcc_stop_bank #(.DATA_W(32), .IMPL_MASK(IMPL_MASK)) u_stop (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .wdata(bus_wdata), .stop_o(stop_q)
  );

  for (genvar g = 0; g < TMR_MAX; g++) begin : g_tmr
    if (g < NUM_TIMERS) begin : g_on
      tcc_channel u_ch (
        .clk(clk), .rst_n(rst_n), .stopped(stop_q[g]),
        .wr_en(bus_we && (bus_addr == ADDR_W'(A_TMR + g))),
        .wr_data(bus_wdata[CTRL_W-1:0]), .src_ticks(src_ticks),
        .ctrl_o(tmr_ctrl[g]), .tick_o(tmr_tick_all[g])
      );
    end else begin : g_off
      assign tmr_ctrl[g]     = '0;
      assign tmr_tick_all[g] = 1'b0;
    end
  end

  if (HAS_OST) begin : g_ost
    tcc_channel u_ch (
      .clk(clk), .rst_n(rst_n), .stopped(stop_q[OST_BIT]),
      .wr_en(bus_we && (bus_addr == ADDR_W'(A_OST))),
      .wr_data(bus_wdata[CTRL_W-1:0]), .src_ticks(src_ticks),
      .ctrl_o(ost_ctrl), .tick_o(ost_tick_o)
    );
  end else begin : g_no_ost
    assign ost_ctrl   = '0;
    assign ost_tick_o = 1'b0;
  end

  tcc_channel u_wdt (
    .clk(clk), .rst_n(rst_n), .stopped(stop_q[WDT_BIT]),
    .wr_en(bus_we && (bus_addr == ADDR_W'(A_WDT))),
    .wr_data(bus_wdata[CTRL_W-1:0]), .src_ticks(src_ticks),
    .ctrl_o(wdt_ctrl), .tick_o(wdt_tick_o)
  );

  assign tmr_tick_o = tmr_tick_all[NUM_TIMERS-1:0];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_STATUS)) bus_rdata = stop_q;
    for (int i = 0; i < TMR_MAX; i++)
      if (bus_addr == ADDR_W'(A_TMR + i)) bus_rdata = {16'h0, tmr_ctrl[i]};
    if (bus_addr == ADDR_W'(A_OST)) bus_rdata = {16'h0, ost_ctrl};
    if (bus_addr == ADDR_W'(A_WDT)) bus_rdata = {16'h0, wdt_ctrl};
  end

  p_rd_writeonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_SET) || bus_addr == ADDR_W'(A_CLR)) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_timer_clk_ctrl.sv
module tb_timer_clk_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [2:0]  src = '0;      // {ext, rtc, pclk}
  logic [5:0]  tmr_tick;
  logic        ost_tick, wdt_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int tick_cnt [10];

  always #5 clk = ~clk;

  timer_clk_ctrl #(.NUM_TIMERS(6), .HAS_OST(1'b1), .ADDR_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata),
    .pclk_tick_i(src[0]), .rtc_tick_i(src[1]), .ext_tick_i(src[2]),
    .tmr_tick_o(tmr_tick), .ost_tick_o(ost_tick), .wdt_tick_o(wdt_tick)
  );

  initial for (int k = 0; k < 10; k++) tick_cnt[k] = 0;
  always @(negedge clk) begin
    for (int k = 0; k < 6; k++) tick_cnt[k] += int'(tmr_tick[k]);
    tick_cnt[8] += int'(ost_tick);
    tick_cnt[9] += int'(wdt_tick);
  end

  // channel index: 0..7 timers, 8 OS timer, 9 watchdog
  function automatic logic [4:0] ctrl_addr(input int ch);
    return (ch < 8) ? 5'(8 + ch) : ((ch == 8) ? 5'd16 : 5'd17);
  endfunction
  function automatic logic [31:0] stop_bit(input int ch);
    return (ch < 8) ? (32'd1 << ch) : ((ch == 8) ? 32'h8000 : 32'h1_0000);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int s);
    @(negedge clk);
    src[s] = 1'b1;
    @(negedge clk);
    src = '0;
  endtask

  typedef struct packed {
    logic [3:0]  ch;
    logic [15:0] ctrl;
    logic [1:0]  s;
    logic [15:0] n;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{4'd0, 16'h0001, 2'd0, 16'd5,    8'd5},  // R6 R7 pclk /1
    '{4'd1, 16'h000A, 2'd1, 16'd9,    8'd2},  // R7 rtc /4
    '{4'd2, 16'h0014, 2'd2, 16'd33,   8'd2},  // R7 ext /16
    '{4'd3, 16'h0003, 2'd1, 16'd6,    8'd0},  // R6 pclk beats rtc
    '{4'd3, 16'h0003, 2'd0, 16'd3,    8'd3},  // R6 pclk wins
    '{4'd4, 16'h0006, 2'd2, 16'd4,    8'd0},  // R6 rtc beats ext
    '{4'd5, 16'h0029, 2'd0, 16'd1024, 8'd1},  // R7 /1024
    '{4'd5, 16'h0039, 2'd0, 16'd2047, 8'd1},  // R7 code 7 as 5
    '{4'd8, 16'h001C, 2'd2, 16'd130,  8'd2},  // R7 OS timer /64
    '{4'd9, 16'h0022, 2'd1, 16'd512,  8'd2},  // R7 watchdog /256
    '{4'd0, 16'h0000, 2'd0, 16'd4,    8'd0},  // R6 no source
    '{4'd1, 16'h0031, 2'd0, 16'd1024, 8'd1}   // R7 code 6 as 5
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R4 reset state
    rd(5'd0, d);  check(d == 32'h0001_803F, "R1 R4 status at reset", d, 32'h0001_803F);
    rd(5'd8, d);  check(d == 0, "R1 ctrl at reset", d, 0);
    rd(5'd17, d); check(d == 0, "R1 wdt ctrl at reset", d, 0);
    check({tmr_tick, ost_tick, wdt_tick} == 0, "R1 ticks low", 32'({tmr_tick, ost_tick, wdt_tick}), 0);

    // R2 / R3 set and clear
    wr(5'd2, 32'h3);   rd(5'd0, d); check(d == 32'h0001_803C, "R3 clear bits", d, 32'h0001_803C);
    wr(5'd1, 32'h1);   rd(5'd0, d); check(d == 32'h0001_803D, "R2 set, zeros ignored", d, 32'h0001_803D);
    wr(5'd2, 32'h0);   rd(5'd0, d); check(d == 32'h0001_803D, "R3 zero write ignored", d, 32'h0001_803D);
    wr(5'd1, 32'hFFFF_FFFF); rd(5'd0, d); check(d == 32'h0001_803F, "R4 R11 set all, only built bits", d, 32'h0001_803F);
    wr(5'd2, 32'hFFFF_FFFF); rd(5'd0, d); check(d == 32'h0, "R3 clear all", d, 32'h0);
    wr(5'd1, 32'h40);  rd(5'd0, d); check(d == 32'h0, "R11 unbuilt stop bit", d, 32'h0);
    rd(5'd1, d); check(d == 0, "R11 stop-set reads 0", d, 0);
    rd(5'd2, d); check(d == 0, "R11 stop-clear reads 0", d, 0);
    wr(5'd14, 32'h1);  rd(5'd14, d); check(d == 0, "R11 unbuilt timer ctrl", d, 0);
    wr(5'd1, 32'hFFFF_FFFF);

    // R5 write lock while stopped
    wr(5'd8, 32'h1);   rd(5'd8, d); check(d == 0, "R5 write while stopped ignored", d, 0);
    wr(5'd2, 32'h1);
    wr(5'd8, 32'hABCD_1234); rd(5'd8, d); check(d == 32'h1234, "R5 16-bit readback", d, 32'h1234);

    // R8 latency and width
    wr(5'd8, 32'h1);
    @(negedge clk);
    check(tmr_tick[0] == 0, "R8 idle before tick", 32'(tmr_tick[0]), 0);
    src[0] = 1'b1;
    @(negedge clk);
    src = '0;
    check(tmr_tick[0] == 1, "R8 pulse one cycle later", 32'(tmr_tick[0]), 1);
    @(negedge clk);
    check(tmr_tick[0] == 0, "R8 single-cycle pulse", 32'(tmr_tick[0]), 0);
    wr(5'd1, 32'h1);

    // table walk
    for (int v = 0; v < 12; v++) begin
      int ch;
      ch = int'(VEC[v].ch);
      wr(5'd1, stop_bit(ch));
      wr(5'd2, stop_bit(ch));
      wr(ctrl_addr(ch), 32'(VEC[v].ctrl));
      base = tick_cnt[ch];
      for (int p = 0; p < int'(VEC[v].n); p++) pulse(int'(VEC[v].s));
      repeat (3) @(negedge clk);
      check(tick_cnt[ch] - base == int'(VEC[v].exp), $sformatf("R6 R7 vector %0d", v),
            32'(tick_cnt[ch] - base), 32'(VEC[v].exp));
      wr(5'd1, stop_bit(ch));
    end

    // R9 stopped channel silent, restart fresh
    wr(5'd2, 32'h4);
    wr(5'd10, 32'h1);
    wr(5'd1, 32'h4);
    base = tick_cnt[2];
    repeat (3) pulse(0);
    repeat (2) @(negedge clk);
    check(tick_cnt[2] == base, "R9 no ticks while stopped", 32'(tick_cnt[2] - base), 0);
    rd(5'd10, d); check(d == 32'h1, "R9 ctrl kept while stopped", d, 32'h1);
    wr(5'd2, 32'h4);
    wr(5'd10, 32'h9);                // pclk /4
    repeat (3) pulse(0);
    wr(5'd1, 32'h4);
    wr(5'd2, 32'h4);
    base = tick_cnt[2];
    repeat (3) pulse(0);
    repeat (2) @(negedge clk);
    check(tick_cnt[2] == base, "R9 count restarted after stop", 32'(tick_cnt[2] - base), 0);
    pulse(0);
    repeat (2) @(negedge clk);
    check(tick_cnt[2] == base + 1, "R9 fresh division completes", 32'(tick_cnt[2] - base), 1);

    // R10 restart on source change
    repeat (3) pulse(0);
    wr(5'd10, 32'hA);                // rtc /4
    base = tick_cnt[2];
    repeat (3) pulse(1);
    repeat (2) @(negedge clk);
    check(tick_cnt[2] == base, "R10 count restarted on change", 32'(tick_cnt[2] - base), 0);
    pulse(1);
    repeat (2) @(negedge clk);
    check(tick_cnt[2] == base + 1, "R10 division after change", 32'(tick_cnt[2] - base), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule